// File: doc/BRIEF.md
# Odd-Increment Integer Square Root

This block computes the integer square root of an unsigned operand: the largest integer whose square does not exceed it. It uses no multiplier and does not guess the result bit by bit. It walks up the perfect squares instead. Each cycle it adds the next odd number (1, 3, 5, 7, ...) to a running square, because the square of n+1 equals the square of n plus 2n+1. The number of squares that fit under the operand is the result. The latency therefore grows with the size of the root. A small operand finishes in a few cycles, and the largest operands take 65536 cycles.

The operand enters through a valid/ready handshake. `in_ready` is high whenever the unit is idle, and an operand is taken on any clock edge where `in_valid` and `in_ready` are both high. While a computation runs, `in_ready` is low and `in_valid` is ignored, so an upstream source must hold its operand until `in_ready` returns. The result side has no back-pressure. `out_valid` is a one-cycle pulse, and `out_root` keeps the result until the next operand is accepted. A consumer that misses the pulse can still read the root while the unit stays idle.

The running square is held one bit wider than the operand. The square that follows the largest possible root therefore cannot wrap around to a small value and let the loop continue.

Top module: `sqrt_odd_isqrt`

## Requirements
- R1: When `out_valid` is high, `out_root` equals floor(sqrt(x)), where x is the accepted 32-bit unsigned operand.
- R2: `in_ready` is high exactly when no computation is running. An operand is accepted on a rising edge with `in_valid` and `in_ready` both high. `in_valid` while `in_ready` is low is ignored, and the running computation and its result are unaffected.
- R3: With result r, `out_valid` rises r+1 cycles after the accepting edge, so an operand of 0 gives `out_valid` and root 0 one cycle after it is accepted.
- R4: `out_valid` is high for a single cycle per accepted operand. `out_root` does not change from that cycle until the next operand is accepted.
- R5: Operands from 65535 squared (0xFFFE0001) up to 0xFFFFFFFF give root 65535 after 65536 cycles. The running square does not wrap.
- R6: After reset, `in_ready` is 1, `out_valid` is 0 and `out_root` is 0.
- R7: A new operand can be accepted in the same cycle that `out_valid` is high, with no idle cycle between the two operands.
- R8: A perfect square k*k gives k, and k*k-1 gives k-1 (for k at least 1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operand offered |
| in_ready | output | 1 | Unit idle; operand taken when in_valid is also high |
| in_data | input | 32 | Unsigned operand |
| out_valid | output | 1 | One-cycle pulse: result ready |
| out_root | output | 16 | Integer square root, held until next accept |

## Verification
A running square or odd step that has gone wrong shows at the ports in two ways. `out_valid` arrives in the wrong cycle, and `out_root` is off by one or more. Both are visible on the first operand whose root passes the corrupted step. The bench checks the exact arrival cycle of every result as well as its value, so a one-step error cannot hide behind a correct-looking final count. A wrap in the running square shows only on operands at the top of the range, either as a hang or as a root of 65535 reported at the wrong time. Those operands are applied directly.

// File: rtl/sqrt_odd_pkg.sv
package sqrt_odd_pkg;
  // Default operand width; the root is half as wide.
  parameter int unsigned DEF_OP_W = 32;

  // Width of the running square: one guard bit above the operand.
  function automatic int unsigned sq_width(input int unsigned op_w);
    return op_w + 1;
  endfunction

  // Width of the odd step: it reaches 2*max_root+1.
  function automatic int unsigned odd_width(input int unsigned op_w);
    return op_w / 2 + 1;
  endfunction
endpackage

// File: rtl/sqrt_odd_acc.sv
module sqrt_odd_acc
  import sqrt_odd_pkg::*;
#(
  parameter int unsigned OP_W = DEF_OP_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load,
  input  logic                step_en,
  input  logic [OP_W-1:0]     op_in,
  output logic                fit,
  output logic [OP_W/2-1:0]   root,
  output logic [OP_W-1:0]     op_held
);
  localparam int unsigned ROOT_W = OP_W / 2;
  localparam int unsigned SQ_W   = sq_width(OP_W);
  localparam int unsigned ODD_W  = odd_width(OP_W);

  logic [OP_W-1:0]   op_q;
  logic [ROOT_W-1:0] root_q;
  logic [ODD_W-1:0]  odd_q;
  logic [SQ_W-1:0]   sq_q;

  logic [OP_W-1:0]   src_op;
  logic [ROOT_W-1:0] src_root;
  logic [ODD_W-1:0]  src_odd;
  logic [SQ_W-1:0]   src_sq;
  logic [ODD_W-1:0]  nxt_odd;
  logic [SQ_W-1:0]   nxt_sq;

  // On load the first candidate square (1) is tested against the new operand.
  always_comb begin
    if (load) begin
      src_op   = op_in;
      src_root = '0;
      src_odd  = ODD_W'(1);
      src_sq   = SQ_W'(1);
    end else begin
      src_op   = op_q;
      src_root = root_q;
      src_odd  = odd_q;
      src_sq   = sq_q;
    end
    nxt_odd = src_odd + ODD_W'(2);
    nxt_sq  = src_sq + SQ_W'(nxt_odd);
  end

  // Guard bit keeps the square above any operand once it passes the range.
  assign fit = ({1'b0, src_op} >= src_sq);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      op_q   <= '0;
      root_q <= '0;
      odd_q  <= '0;
      sq_q   <= '0;
    end else if (load || step_en) begin
      op_q <= src_op;
      if (fit) begin
        root_q <= src_root + ROOT_W'(1);
        odd_q  <= nxt_odd;
        sq_q   <= nxt_sq;
      end else begin
        root_q <= src_root;
      end
    end
  end

  assign root    = root_q;
  assign op_held = op_q;
endmodule

// File: rtl/sqrt_odd_seq.sv
module sqrt_odd_seq (
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  input  logic fit,
  output logic in_ready,
  output logic load,
  output logic step_en,
  output logic done
);
  logic busy_q;
  logic done_q;
  logic active;

  assign in_ready = !busy_q;
  assign load     = in_valid && !busy_q;
  assign step_en  = busy_q;
  assign active   = load || busy_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      busy_q <= active && fit;
      done_q <= active && !fit;
    end
  end

  assign done = done_q;
endmodule

// File: rtl/sqrt_odd_isqrt.sv
module sqrt_odd_isqrt
  import sqrt_odd_pkg::*;
#(
  parameter int unsigned OP_W = DEF_OP_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [OP_W-1:0]     in_data,
  output logic                out_valid,
  output logic [OP_W/2-1:0]   out_root
);
  logic            load;
  logic            step_en;
  logic            fit;
  logic [OP_W-1:0] held_op;

  sqrt_odd_seq u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .fit      (fit),
    .in_ready (in_ready),
    .load     (load),
    .step_en  (step_en),
    .done     (out_valid)
  );

  sqrt_odd_acc #(.OP_W(OP_W)) u_acc (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (load),
    .step_en (step_en),
    .op_in   (in_data),
    .fit     (fit),
    .root    (out_root),
    .op_held (held_op)
  );
endmodule

// File: rtl/sqrt_odd_isqrt_chk.sv
module sqrt_odd_isqrt_chk #(
  parameter int unsigned OP_W = 32
) (
  input logic                clk,
  input logic                rst_n,
  input logic                in_valid,
  input logic                in_ready,
  input logic                out_valid,
  input logic [OP_W/2-1:0]   out_root,
  input logic [OP_W-1:0]     held_op
);
  localparam int unsigned ROOT_W = OP_W / 2;
  localparam int unsigned EXT_W  = OP_W + 2;

  logic [EXT_W-1:0] r_ext, r1_ext, r_sq, r1_sq, op_ext;
  assign r_ext  = EXT_W'(out_root);
  assign r1_ext = EXT_W'(out_root) + EXT_W'(1);
  assign r_sq   = r_ext * r_ext;
  assign r1_sq  = r1_ext * r1_ext;
  assign op_ext = EXT_W'(held_op);

  // R1
  root_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (r_sq <= op_ext) && (r1_sq > op_ext));

  // R2
  busy_ignores_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |=> (out_valid && $stable(out_root)) ||
                  (out_root == $past(out_root) + ROOT_W'(1)));

  // R4
  pulse_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !in_valid) |=> !out_valid);

  // R4
  hold_root_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ready && !in_valid) |=> $stable(out_root));

  // R7
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> in_ready);
endmodule

bind sqrt_odd_isqrt sqrt_odd_isqrt_chk #(.OP_W(OP_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_root  (out_root),
  .held_op   (held_op)
);

// File: tb/sqrt_odd_isqrt_bench.sv
`timescale 1ns/1ps
module sqrt_odd_isqrt_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] in_data = '0;
  logic        in_ready;
  logic        out_valid;
  logic [15:0] out_root;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  sqrt_odd_isqrt u_sqrt_odd_isqrt (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .out_valid(out_valid), .out_root(out_root)
  );

  function automatic longint ref_root(input longint x);
    longint lo = 0;
    longint hi = 65536;
    while (hi - lo > 1) begin
      longint mid = (lo + hi) / 2;
      if (mid * mid <= x) lo = mid; else hi = mid;
    end
    return lo;
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Counts negedges after the accepting edge until out_valid is seen.
  task automatic wait_done(output int lat);
    lat = 0;
    do begin
      @(negedge clk);
      lat++;
    end while (!out_valid && lat < 70000);
  endtask

  task automatic run_op(input logic [31:0] x, input string req);
    int lat;
    longint r;
    r = ref_root(longint'(x));
    @(negedge clk);
    chk(in_ready == 1'b1, "R2 ready before accept", in_ready, 1);
    in_valid = 1'b1;
    in_data  = x;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    lat = 1;
    while (!out_valid && lat < 70000) begin
      @(negedge clk);
      lat++;
    end
    chk(out_root == r, {req, " root"}, out_root, r);
    chk(lat == r + 1, "R3 latency", lat, r + 1);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(in_ready == 1'b1, "R6 in_ready", in_ready, 1);
    chk(out_valid == 1'b0, "R6 out_valid", out_valid, 0);
    chk(out_root == 16'd0, "R6 out_root", out_root, 0);
  endtask

  task automatic t_small();
    // R1 R3: zero finishes one cycle after accept
    run_op(32'd0, "R3 zero");
    run_op(32'd1, "R1");
    run_op(32'd2, "R1");
    run_op(32'd3, "R1");
    run_op(32'd101, "R1");
    run_op(32'd6789, "R1");
    run_op(32'd1000000, "R1");
  endtask

  task automatic t_squares();
    // R8
    run_op(32'd4, "R8 square");
    run_op(32'd8, "R8 below square");
    run_op(32'd9, "R8 square");
    run_op(32'd24, "R8 below square");
    run_op(32'd1048576, "R8 square");
    run_op(32'd1048575, "R8 below square");
  endtask

  task automatic t_hold();
    logic [15:0] seen;
    run_op(32'd50, "R1");
    seen = out_root;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      chk(out_valid == 1'b0, "R4 single pulse", out_valid, 0);
      chk(out_root == seen, "R4 root held", out_root, seen);
    end
  endtask

  task automatic t_busy_ignore();
    int lat;
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = 32'd10000;
    @(posedge clk);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      in_data = 32'd0;
      chk(in_ready == 1'b0, "R2 busy not ready", in_ready, 0);
    end
    in_valid = 1'b0;
    lat = 5;
    while (!out_valid && lat < 70000) begin
      @(negedge clk);
      lat++;
    end
    chk(out_root == 16'd100, "R2 start ignored root", out_root, 100);
    chk(lat == 101, "R2 start ignored latency", lat, 101);
  endtask

  task automatic t_back_to_back();
    int lat;
    run_op(32'd30, "R1");
    // out_valid is high now: offer the next operand in this very cycle
    chk(in_ready == 1'b1, "R7 ready during done", in_ready, 1);
    in_valid = 1'b1;
    in_data  = 32'd49;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    chk(out_valid == 1'b0, "R7 pulse ends", out_valid, 0);
    lat = 1;
    while (!out_valid && lat < 70000) begin
      @(negedge clk);
      lat++;
    end
    chk(out_root == 16'd7, "R7 second root", out_root, 7);
    chk(lat == 8, "R7 second latency", lat, 8);
  endtask

  task automatic t_top_range();
    // R5: no wrap of the running square at the top of the range
    run_op(32'hFFFF_FFFF, "R5 max operand");
    run_op(32'hFFFE_0001, "R5 largest square");
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 190000, 0);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_small();
    t_squares();
    t_hold();
    t_busy_ignore();
    t_back_to_back();
    t_top_range();
    repeat (2) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule